// File: doc/BRIEF.md
# Outstanding Line-Miss Tracker with Load Merging

This block sits beside a first-level data cache and keeps track of cache lines that have missed and are being fetched from the next cache level. When a load misses, the tracker either claims a free slot and sends one line request downstream, or, if that line is already being fetched, records the load in the slot that is already waiting. Loads that share a line therefore cost a single downstream request.

The downstream request carries the slot number, and the fill response returns that number together with the whole line. The slot keeps the line and hands back the waiting loads one per cycle, in the order they arrived. Each load gets its tag and the word it asked for. The slot is released when its last load has been handed back. When no slot can take a miss, the tracker raises a stall in the same cycle. The miss is not recorded, and the cache must present it again later.

Top module: `line_miss_tracker`

## Requirements
- R1: After reset, `req_valid`, `done_valid` and `miss_stall` are 0, and all 16 slots are free.
- R2: A miss to a line that no waiting slot holds, while some slot is free, takes the lowest-numbered free slot. In the next cycle `req_valid` is 1 for one cycle, with `req_line` equal to `miss_addr[31:6]` and `req_id` equal to that slot number.
- R3: A miss to a line that a slot still waiting for its fill already holds is attached to that slot, and no request is issued (`req_valid` stays 0 in the next cycle).
- R4: Lines are compared at 64-byte granularity: two addresses that differ only in bits [5:0] belong to the same line.
- R5: A slot records at most 4 loads. A further miss to its line raises `miss_stall` in that cycle and is not recorded.
- R6: When all 16 slots are busy and none holds the miss's line, `miss_stall` is 1 in that cycle, and no request is issued.
- R7: When `fill_valid` is 1 with `fill_id` naming a waiting slot, that slot stores `fill_line`. From the next cycle on, its loads appear on `done_valid`/`done_tag`/`done_data`, one per cycle and in arrival order. `done_data` is the 32-bit word `fill_line[32*k +: 32]`, where k is `miss_addr[5:2]` of that load.
- R8: A slot becomes free in the cycle after its last load is completed, and it can then be allocated again. A miss to a line whose slot has already been filled and is handing back loads is not attached to that slot; it allocates a new slot and issues a new request.
- R9: When several slots hold filled lines, the lowest-numbered one supplies the completion in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed this cycle |
| miss_addr | input | 32 | Byte address of the missing load |
| miss_tag | input | 6 | Load identifier returned on completion |
| miss_stall | output | 1 | Miss cannot be accepted this cycle |
| req_valid | output | 1 | Line request to the next level |
| req_line | output | 26 | Line address of the request |
| req_id | output | 4 | Slot number carried by the request |
| fill_valid | input | 1 | Line data returning from the next level |
| fill_id | input | 4 | Slot number the fill belongs to |
| fill_line | input | 512 | Returned line, word k in bits [32k+31:32k] |
| done_valid | output | 1 | A load is completed this cycle |
| done_tag | output | 6 | Tag of the completed load |
| done_data | output | 32 | Requested word of the completed load |

## Verification
The bench targets the points where merging goes wrong. A second miss to the same line with a different low offset must not raise a request; a design that compares full addresses would issue a duplicate. A fifth load to one line and a seventeenth distinct line must both stall; a design that lets either through would overwrite a waiting load or hand out a busy slot. A miss that arrives while its line is being handed back must take a fresh slot; a design that attached it to the draining slot would lose it or return it with a stale word. A fill landing on a lower slot while a higher one drains checks the priority order, and a reallocation after a slot has drained checks that the slot was really freed.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } slot_state_t;

  // Index of the lowest set bit among the first n bits of v (0 when none).
  function automatic int unsigned lowest_set(input logic [63:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < n && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/lmt_slot.sv
module lmt_slot
  import lmt_pkg::*;
#(
  parameter int LADDR_W = 26,
  parameter int LINE_W  = 512,
  parameter int WORD_W  = 32,
  parameter int TAG_W   = 6,
  parameter int WSEL_W  = 4,
  parameter int WAITERS = 4,
  localparam int CNT_W  = $clog2(WAITERS + 1),
  localparam int PTR_W  = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  input  logic               merge_i,
  input  logic [LADDR_W-1:0] line_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [WSEL_W-1:0]  wsel_i,
  input  logic               fill_i,
  input  logic [LINE_W-1:0]  fill_data_i,
  input  logic               pop_i,
  output logic               waiting_o,
  output logic               filled_o,
  output logic [LADDR_W-1:0] line_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [TAG_W-1:0]   head_tag_o,
  output logic [WORD_W-1:0]  head_word_o
);
  slot_state_t        state;
  logic [CNT_W-1:0]   cnt;
  logic [PTR_W-1:0]   rd;
  logic [LADDR_W-1:0] line_q;
  logic [LINE_W-1:0]  data_q;
  logic [TAG_W-1:0]   tags  [WAITERS];
  logic [WSEL_W-1:0]  wsels [WAITERS];
  logic               last_pop;

  assign last_pop = (CNT_W'(rd) + CNT_W'(1)) == cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FREE;
      cnt   <= '0;
      rd    <= '0;
    end else if (alloc_i) begin
      state    <= ST_WAIT;
      line_q   <= line_i;
      tags[0]  <= tag_i;
      wsels[0] <= wsel_i;
      cnt      <= CNT_W'(1);
      rd       <= '0;
    end else begin
      if (merge_i) begin
        tags[PTR_W'(cnt)]  <= tag_i;
        wsels[PTR_W'(cnt)] <= wsel_i;
        cnt                <= cnt + CNT_W'(1);
      end
      if (fill_i && state == ST_WAIT) begin
        state  <= ST_DRAIN;
        data_q <= fill_data_i;
      end
      if (pop_i) begin
        if (last_pop) begin
          state <= ST_FREE;
          cnt   <= '0;
          rd    <= '0;
        end else begin
          rd <= rd + PTR_W'(1);
        end
      end
    end
  end

  assign waiting_o   = (state == ST_WAIT);
  assign filled_o    = (state == ST_DRAIN);
  assign line_o      = line_q;
  assign cnt_o       = cnt;
  assign head_tag_o  = tags[rd];
  assign head_word_o = data_q[wsels[rd]*WORD_W +: WORD_W];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WAITERS)); // R5
  AST_MERGE_INTO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> (state == ST_WAIT) && (cnt < CNT_W'(WAITERS))); // R3
  AST_POP_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (state == ST_DRAIN)); // R7
  AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && last_pop && !alloc_i) |=> (state == ST_FREE)); // R8
endmodule

// File: rtl/lmt_lookup.sv
module lmt_lookup
  import lmt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int LADDR_W = 26,
  parameter int WAITERS = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(WAITERS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] miss_line_i,
  input  logic [ENTRIES-1:0] waiting_i,
  input  logic [ENTRIES-1:0] filled_i,
  input  logic [LADDR_W-1:0] lines_i [ENTRIES],
  input  logic [CNT_W-1:0]   cnts_i  [ENTRIES],
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               hit_full_o,
  output logic               free_o,
  output logic [IDX_W-1:0]   free_idx_o
);
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] free_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]  = waiting_i[g] && (lines_i[g] == miss_line_i);
    assign free_vec[g] = !waiting_i[g] && !filled_i[g];
  end

  assign hit_o      = |hit_vec;
  assign free_o     = |free_vec;
  assign hit_idx_o  = IDX_W'(lowest_set(64'(hit_vec), ENTRIES));
  assign free_idx_o = IDX_W'(lowest_set(64'(free_vec), ENTRIES));
  assign hit_full_o = (cnts_i[hit_idx_o] == CNT_W'(WAITERS));

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/lmt_drain_arb.sv
module lmt_drain_arb
  import lmt_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] filled_i,
  output logic               grant_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic [ENTRIES-1:0] pop_o
);
  assign grant_o     = |filled_i;
  assign grant_idx_o = IDX_W'(lowest_set(64'(filled_i), ENTRIES));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pop
    assign pop_o[g] = grant_o && (grant_idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/line_miss_tracker.sv
module line_miss_tracker
  import lmt_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int WAITERS    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int TAG_W      = 6,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int CNT_W     = $clog2(WAITERS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [ADDR_W-1:0]  miss_addr,
  input  logic [TAG_W-1:0]   miss_tag,
  output logic               miss_stall,
  output logic               req_valid,
  output logic [LADDR_W-1:0] req_line,
  output logic [IDX_W-1:0]   req_id,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_id,
  input  logic [LINE_W-1:0]  fill_line,
  output logic               done_valid,
  output logic [TAG_W-1:0]   done_tag,
  output logic [WORD_W-1:0]  done_data
);
  logic [LADDR_W-1:0] miss_line;
  logic [WSEL_W-1:0]  miss_wsel;
  logic               unused_byte_bits;

  assign miss_line        = miss_addr[ADDR_W-1:OFF_W];
  assign miss_wsel        = miss_addr[OFF_W-1:OFF_W-WSEL_W];
  assign unused_byte_bits = ^miss_addr[OFF_W-WSEL_W-1:0];

  logic [ENTRIES-1:0] e_waiting, e_filled, e_pop;
  logic [LADDR_W-1:0] e_line [ENTRIES];
  logic [CNT_W-1:0]   e_cnt  [ENTRIES];
  logic [TAG_W-1:0]   e_tag  [ENTRIES];
  logic [WORD_W-1:0]  e_word [ENTRIES];

  logic             hit, hit_full, free_any, grant;
  logic [IDX_W-1:0] hit_idx, free_idx, grant_idx;

  // Named events used by the slots and by the assertions.
  logic accept, do_alloc, do_merge;

  lmt_lookup #(.ENTRIES(ENTRIES), .LADDR_W(LADDR_W), .WAITERS(WAITERS)) u_lookup (
    .clk(clk), .rst_n(rst_n), .miss_line_i(miss_line),
    .waiting_i(e_waiting), .filled_i(e_filled), .lines_i(e_line), .cnts_i(e_cnt),
    .hit_o(hit), .hit_idx_o(hit_idx), .hit_full_o(hit_full),
    .free_o(free_any), .free_idx_o(free_idx)
  );

  assign miss_stall = miss_valid && (hit ? hit_full : !free_any);
  assign accept     = miss_valid && !miss_stall;
  assign do_alloc   = accept && !hit;
  assign do_merge   = accept && hit;

  lmt_drain_arb #(.ENTRIES(ENTRIES)) u_arb (
    .filled_i(e_filled), .grant_o(grant), .grant_idx_o(grant_idx), .pop_o(e_pop)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    lmt_slot #(
      .LADDR_W(LADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .TAG_W(TAG_W),
      .WSEL_W(WSEL_W), .WAITERS(WAITERS)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(do_alloc && free_idx == IDX_W'(g)),
      .merge_i(do_merge && hit_idx == IDX_W'(g)),
      .line_i(miss_line), .tag_i(miss_tag), .wsel_i(miss_wsel),
      .fill_i(fill_valid && fill_id == IDX_W'(g)), .fill_data_i(fill_line),
      .pop_i(e_pop[g]),
      .waiting_o(e_waiting[g]), .filled_o(e_filled[g]), .line_o(e_line[g]),
      .cnt_o(e_cnt[g]), .head_tag_o(e_tag[g]), .head_word_o(e_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_line  <= '0;
      req_id    <= '0;
    end else begin
      req_valid <= do_alloc;
      if (do_alloc) begin
        req_line <= miss_line;
        req_id   <= free_idx;
      end
    end
  end

  assign done_valid = grant;
  assign done_tag   = e_tag[grant_idx];
  assign done_data  = e_word[grant_idx];

  AST_ALLOC_SENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> req_valid && req_line == $past(miss_line)); // R2
  AST_MERGE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge |=> !req_valid); // R3
  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_stall) |=> !req_valid); // R6
  AST_FILL_HITS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> e_waiting[fill_id]); // R7
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(e_pop)); // R9
endmodule

// File: tb/line_miss_tracker_tb.sv
`timescale 1ns/1ps
module line_miss_tracker_tb;
  localparam int AW = 32, TW = 6, IW = 4, LW = 512;

  logic          clk = 0, rst_n = 0;
  logic          miss_valid = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [TW-1:0] miss_tag = '0;
  logic          miss_stall, req_valid, done_valid;
  logic [25:0]   req_line;
  logic [IW-1:0] req_id;
  logic          fill_valid = 0;
  logic [IW-1:0] fill_id = '0;
  logic [LW-1:0] fill_line = '0;
  logic [TW-1:0] done_tag;
  logic [31:0]   done_data;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  line_miss_tracker u_dut (.*);

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int line, input int word);
    return AW'((line << 6) | (word << 2));
  endfunction

  function automatic logic [LW-1:0] mk_line(input int seed);
    logic [LW-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = {16'(seed), 16'(w)};
    return l;
  endfunction

  task automatic step(); @(posedge clk); #1; endtask

  // Present one miss; check the stall that cycle and the request in the next.
  task automatic miss(input int line, input int word, input int tag,
                      input bit exp_stall, input bit exp_req, input int exp_id, input string rq);
    miss_valid = 1; miss_addr = mk(line, word) | AW'(word & 3); miss_tag = TW'(tag);
    #1;
    check(miss_stall == exp_stall, rq, miss_stall, exp_stall);
    @(posedge clk); #1;
    miss_valid = 0;
    check(req_valid == exp_req, rq, req_valid, exp_req);
    if (exp_req) begin
      check(req_id == IW'(exp_id), rq, req_id, exp_id);
      check(req_line == 26'(line), rq, req_line, line);
    end
  endtask

  task automatic fill(input int id, input int seed);
    fill_valid = 1; fill_id = IW'(id); fill_line = mk_line(seed);
    step();
    fill_valid = 0;
  endtask

  task automatic done(input int tag, input int seed, input int word, input bit adv, input string rq);
    check(done_valid == 1'b1, rq, done_valid, 1);
    check(done_tag == TW'(tag), rq, done_tag, tag);
    check(done_data == {16'(seed), 16'(word)}, rq, done_data, {16'(seed), 16'(word)});
    if (adv) step();
  endtask

  task automatic idle_done(input string rq);
    check(done_valid == 1'b0, rq, done_valid, 0);
  endtask

  task automatic t_reset();
    check(req_valid == 0, "R1", req_valid, 0);
    check(done_valid == 0, "R1", done_valid, 0);
    check(miss_stall == 0, "R1", miss_stall, 0);
  endtask

  task automatic t_merge();
    miss(100, 3, 1, 0, 1, 0, "R2");
    miss(100, 5, 2, 0, 0, 0, "R3 R4");          // same line, other offset
    miss(101, 3, 3, 0, 1, 1, "R2 R4");          // next line is distinct
    fill(0, 16'hA0);
    done(1, 16'hA0, 3, 1, "R7");
    done(2, 16'hA0, 5, 1, "R7");
    idle_done("R8");
    fill(1, 16'hA1);
    done(3, 16'hA1, 3, 1, "R7");
    idle_done("R8");
  endtask

  task automatic t_cap();
    miss(200, 0, 10, 0, 1, 0, "R2 R8");         // slot 0 reused
    miss(200, 7, 11, 0, 0, 0, "R3");
    miss(200, 9, 12, 0, 0, 0, "R3");
    miss(200, 15, 13, 0, 0, 0, "R3");
    miss(200, 1, 14, 1, 0, 0, "R5");            // fifth load stalls
    fill(0, 16'hB0);
    done(10, 16'hB0, 0, 1, "R5 R7");
    done(11, 16'hB0, 7, 1, "R7");
    done(12, 16'hB0, 9, 1, "R7");
    done(13, 16'hB0, 15, 1, "R5 R7");
    idle_done("R5");
  endtask

  task automatic t_full();
    for (int k = 0; k < 16; k++) miss(300 + k, k, k, 0, 1, k, "R2 R6");
    miss(400, 0, 40, 1, 0, 0, "R6");
    miss(305, 2, 41, 0, 0, 0, "R3 R6");
    fill(5, 16'hC5);
    done(5, 16'hC5, 5, 1, "R7");
    done(41, 16'hC5, 2, 1, "R7");
    idle_done("R8");
    miss(400, 4, 42, 0, 1, 5, "R8");            // freed slot is reused
    for (int k = 0; k < 16; k++) begin
      fill(k, 16'hD0 + k);
      if (k == 5) done(42, 16'hD5, 4, 1, "R7");
      else done(k, 16'hD0 + k, k, 1, "R7");
    end
    idle_done("R8");
  endtask

  task automatic t_prio();
    miss(500, 1, 20, 0, 1, 0, "R2");
    miss(501, 2, 21, 0, 1, 1, "R2");
    miss(501, 3, 22, 0, 0, 0, "R3");
    fill(1, 16'hE1);
    done(21, 16'hE1, 2, 0, "R9");
    fill(0, 16'hE0);                            // pops slot 1 head at this edge
    done(20, 16'hE0, 1, 1, "R9");
    done(22, 16'hE1, 3, 1, "R9");
    idle_done("R9");
  endtask

  task automatic t_drain_miss();
    miss(600, 0, 30, 0, 1, 0, "R2");
    miss(600, 1, 31, 0, 0, 0, "R3");
    fill(0, 16'hF0);
    done(30, 16'hF0, 0, 0, "R7");
    miss(600, 2, 32, 0, 1, 1, "R8");            // no merge into a draining slot
    done(31, 16'hF0, 1, 1, "R8");
    idle_done("R8");
    fill(1, 16'hF1);
    done(32, 16'hF1, 2, 1, "R8");
    idle_done("R8");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_merge();
    t_cap();
    t_full();
    t_prio();
    t_drain_miss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule